// File: doc/BRIEF.md
# Nested Strided Address Walker

This block generates the address sequence for a load/store unit that reads or writes multi-dimensional data. Each of up to four dimensions is described by three configuration values: a base address, a stride and an element count. A scalar controller writes these values through a small write port. A start pulse then begins a walk, and every step pulse from the microcode moves the address to the next element. The address sequence itself is produced by the block. When each access happens is decided by whoever drives the step input.

Dimension 0 is the innermost dimension. When dimension 0 has shown its last element, the next step carries into the lowest dimension that still has elements left. That dimension moves by its own stride, and every dimension below it restarts from the new position. On its first pass, each dimension starts at its own base address. An unused dimension is left at count 1 and never advances. A walk with any count of zero is empty and finishes at once.

As an example, take base 1, stride 3, count 3 in dimension 0 and base 1, stride 8, count 4 in dimension 1. The walk visits a 4x3 matrix inside a space eight addresses wide: 1, 4, 7, 9, 12, 15, 17, and so on. All address arithmetic is modulo 2^ADDR_W.

Top module: `stride_walker`

## Requirements
- R1: After reset, busy, done, last and all wrap bits are 0, addr is 0, and every dimension holds base 0, stride 0 and count 1.
- R2: A start pulse with all counts nonzero gives busy=1, done=0 and addr equal to the base of dimension 0 on the next cycle. Every dimension restarts at index 0 and at its own base.
- R3: A step while busy, with dimension 0 not yet at its final index, adds the dimension 0 stride to addr one cycle later.
- R4: A step while busy, with dimensions 0..j-1 at their final index and dimension j not, advances dimension j by its stride. Each lower dimension is reset to index 0 and to the new position of dimension j, so addr becomes that position.
- R5: wrap[k] is 1 exactly while busy is 1 and dimension k is at index count_k-1.
- R6: last is 1 exactly while busy is 1 and every wrap bit is 1.
- R7: A step while last is 1 clears busy, sets done and holds addr.
- R8: A step while busy is 0 has no effect: addr, busy, done, last and wrap keep their values.
- R9: A start pulse while any dimension count is 0 gives busy=0 and done=1 on the next cycle.
- R10: A start pulse during a walk abandons that walk and begins a new one as in R2. Start takes priority over a step in the same cycle.
- R11: The configuration port decodes cfg_sel as 0 for base, 1 for stride and 2 for count (the low CNT_W bits of cfg_wdata), with cfg_dim selecting the dimension. A write with cfg_sel=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_dim | input | 2 | Dimension selected by a configuration write |
| cfg_sel | input | 2 | Field selected: 0 base, 1 stride, 2 count, 3 none |
| cfg_wdata | input | ADDR_W | Configuration write data |
| start | input | 1 | Begin a new walk |
| step | input | 1 | Advance to the next element |
| addr | output | ADDR_W | Current element address |
| busy | output | 1 | Walk in progress, addr valid |
| wrap | output | NDIM | Per-dimension final-index flags |
| last | output | 1 | Current element is the final one of the walk |
| done | output | 1 | Walk finished or empty |

## Verification
The bench builds the block with its defaults: four dimensions, 16-bit addresses and 8-bit counts. Counts are kept between 0 and 4, so carries through all four levels, walks that are entirely count-1 dimensions, and empty walks occur many times within a few hundred cycles. Random 16-bit strides and bases make the address sum wrap past 2^16 often, so the modulo behaviour is exercised as well. Random gaps between steps, and restarts in the middle of a walk, test that stepping is gated and that start has priority.

// File: rtl/walk_pkg.sv
package walk_pkg;

    // Field selector for configuration writes
    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_STRIDE = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    localparam int DEF_NDIM   = 4;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_CNT_W  = 8;

    // Outcome of one clock for the walk controller
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_LOAD    = 2'd1,
        ACT_ADVANCE = 2'd2,
        ACT_FINISH  = 2'd3
    } walk_act_e;

endpackage

// File: rtl/walk_cfg_regs.sv
module walk_cfg_regs
    import walk_pkg::*;
#(
    parameter int NDIM   = DEF_NDIM,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W,
    localparam int DIM_W = (NDIM > 1) ? $clog2(NDIM) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [DIM_W-1:0]              dim,
    input  logic [1:0]                    sel,
    input  logic [ADDR_W-1:0]             wdata,
    output logic [NDIM-1:0][ADDR_W-1:0]   base,
    output logic [NDIM-1:0][ADDR_W-1:0]   stride,
    output logic [NDIM-1:0][CNT_W-1:0]    count
);
    cfg_sel_e sel_e;
    assign sel_e = cfg_sel_e'(sel);

    for (genvar k = 0; k < NDIM; k++) begin : g_dim
        logic hit;
        assign hit = we && (dim == DIM_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                base[k]   <= '0;
                stride[k] <= '0;
                count[k]  <= CNT_W'(1);
            end else if (hit) begin
                case (sel_e)
                    SEL_BASE:   base[k]   <= wdata;
                    SEL_STRIDE: stride[k] <= wdata;
                    SEL_COUNT:  count[k]  <= wdata[CNT_W-1:0];
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/walk_carry.sv
module walk_carry #(
    parameter int NDIM = 4
) (
    input  logic [NDIM-1:0] fin,
    output logic [NDIM-1:0] adv,
    output logic [NDIM-1:0] below,
    output logic            all_fin
);
    // prefix[k] = all dimensions below k are at their final index
    logic [NDIM:0] prefix;
    assign prefix[0] = 1'b1;

    for (genvar k = 0; k < NDIM; k++) begin : g_chain
        assign prefix[k+1] = prefix[k] & fin[k];
        assign adv[k]      = prefix[k] & ~fin[k];
    end

    // below[k] = some dimension above k is the one advancing
    for (genvar k = 0; k < NDIM; k++) begin : g_below
        if (k == NDIM - 1) begin : g_top
            assign below[k] = 1'b0;
        end else begin : g_mid
            assign below[k] = |adv[NDIM-1:k+1];
        end
    end

    assign all_fin = prefix[NDIM];
endmodule

// File: rtl/walk_dim.sv
module walk_dim #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              inc,
    input  logic              reload,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] reload_pos,
    output logic [ADDR_W-1:0] pos,
    output logic [ADDR_W-1:0] pos_next,
    output logic              fin
);
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] idx_max;

    assign idx_max  = count - CNT_W'(1);
    assign fin      = (idx == idx_max);
    assign pos_next = pos + stride;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            pos <= '0;
        end else if (load) begin
            idx <= '0;
            pos <= base;
        end else if (inc) begin
            idx <= idx + CNT_W'(1);
            pos <= pos_next;
        end else if (reload) begin
            idx <= '0;
            pos <= reload_pos;
        end
    end
endmodule

// File: rtl/stride_walker.sv
module stride_walker
    import walk_pkg::*;
#(
    parameter int NDIM   = DEF_NDIM,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W,
    localparam int DIM_W = (NDIM > 1) ? $clog2(NDIM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DIM_W-1:0]  cfg_dim,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic [NDIM-1:0]   wrap,
    output logic              last,
    output logic              done
);
    logic [NDIM-1:0][ADDR_W-1:0] base, stride, pos, pos_next;
    logic [NDIM-1:0][CNT_W-1:0]  count;
    logic [NDIM-1:0]             fin, adv, below, zero_cnt;
    logic                        all_fin;
    logic [ADDR_W-1:0]           carry_pos;
    walk_act_e                   act;

    walk_cfg_regs #(.NDIM(NDIM), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .dim(cfg_dim), .sel(cfg_sel),
        .wdata(cfg_wdata), .base(base), .stride(stride), .count(count)
    );

    walk_carry #(.NDIM(NDIM)) u_carry (
        .fin(fin), .adv(adv), .below(below), .all_fin(all_fin)
    );

    // Controller decision for this clock
    always_comb begin
        if (start)                        act = ACT_LOAD;
        else if (step && busy && all_fin) act = ACT_FINISH;
        else if (step && busy)            act = ACT_ADVANCE;
        else                              act = ACT_HOLD;
    end

    // Next position of whichever dimension takes the carry (one-hot select)
    always_comb begin
        carry_pos = '0;
        for (int k = 0; k < NDIM; k++) begin
            if (adv[k]) carry_pos = carry_pos | pos_next[k];
        end
    end

    for (genvar k = 0; k < NDIM; k++) begin : g_dim
        assign zero_cnt[k] = (count[k] == '0);
        walk_dim #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dim (
            .clk(clk), .rst(rst),
            .load(act == ACT_LOAD),
            .inc((act == ACT_ADVANCE) && adv[k]),
            .reload((act == ACT_ADVANCE) && below[k]),
            .base(base[k]), .stride(stride[k]), .count(count[k]),
            .reload_pos(carry_pos),
            .pos(pos[k]), .pos_next(pos_next[k]), .fin(fin[k])
        );
        assign wrap[k] = busy & fin[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    busy <= ~|zero_cnt;
                    done <= |zero_cnt;
                end
                ACT_FINISH: begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign addr = pos[0];
    assign last = busy & all_fin;

endmodule

// File: rtl/stride_walker_chk.sv
module stride_walker_chk #(
    parameter int NDIM   = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              step,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic [NDIM-1:0]   wrap,
    input logic              last,
    input logic              done
);
    // R2 / R9: a start always yields exactly one of busy or done
    p_start_outcome_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy ^ done));

    // R5: wrap bits are silent while no walk runs
    p_wrap_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (wrap == '0));

    // R6: last only with every dimension at its final index
    p_last_all_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        last |-> (busy && (&wrap)));

    // R7: stepping past the final element ends the walk, address held
    p_finish_r7: assert property (@(posedge clk) disable iff (rst)
        (last && step && !start) |=> (done && !busy && $stable(addr)));

    // R8: without start, an idle walker keeps its address and flags
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(addr) && !busy && $stable(done)));

    // R3: no step and no start leaves the address untouched
    p_no_step_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!step && !start) |=> $stable(addr));

    // busy and done are never both set
    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

bind stride_walker stride_walker_chk #(.NDIM(NDIM), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .step(step), .addr(addr),
    .busy(busy), .wrap(wrap), .last(last), .done(done)
);

// File: tb/sim_stride_walker.sv
`timescale 1ns/1ps
module sim_stride_walker;
    localparam int NDIM = 4, AW = 16, CW = 8;

    logic clk = 0, rst = 1;
    logic cfg_we = 0, start = 0, step = 0;
    logic [1:0] cfg_dim = 0, cfg_sel = 0;
    logic [AW-1:0] cfg_wdata = 0;
    logic [AW-1:0] addr;
    logic busy, last, done;
    logic [NDIM-1:0] wrap;

    int nchk = 0, nerr = 0;

    // bench copy of configuration and walk state
    logic [AW-1:0] kb [NDIM], ks [NDIM], m_pos [NDIM];
    logic [CW-1:0] ki [NDIM], m_idx [NDIM];
    logic m_busy = 0, m_done = 0;

    always #2 clk = ~clk;

    stride_walker #(.NDIM(NDIM), .ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dim(cfg_dim), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .step(step), .addr(addr),
        .busy(busy), .wrap(wrap), .last(last), .done(done)
    );

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL watchdog: run did not finish (actual hung, expected end)");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    function automatic logic [NDIM-1:0] exp_wrap();
        logic [NDIM-1:0] w;
        for (int k = 0; k < NDIM; k++)
            w[k] = m_busy && (m_idx[k] == ki[k] - CW'(1));
        return w;
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp,
                       input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [NDIM-1:0] ew;
        ew = exp_wrap();
        chk(req, AW'(busy), AW'(m_busy), "busy");
        chk(req, AW'(done), AW'(m_done), "done");
        chk("R5", AW'(wrap), AW'(ew), "wrap");
        chk("R6", AW'(last), AW'(m_busy && (&ew)), "last");
        chk(req, addr, m_pos[0], "addr");
    endtask

    // model of one clock edge, following R2..R10
    task automatic model_edge(input bit st, input bit sp);
        int j;
        bit anyz;
        if (st) begin
            anyz = 0;
            for (int k = 0; k < NDIM; k++) begin
                m_idx[k] = 0; m_pos[k] = kb[k];
                if (ki[k] == 0) anyz = 1;
            end
            m_busy = !anyz; m_done = anyz;
        end else if (sp && m_busy) begin
            j = -1;
            for (int k = NDIM - 1; k >= 0; k--)
                if (m_idx[k] != ki[k] - CW'(1)) j = k;
            for (int k = 0; k < NDIM; k++)
                if (k < j && m_idx[k] != ki[k] - CW'(1)) j = k;
            if (j < 0) begin
                m_busy = 0; m_done = 1;
            end else begin
                m_idx[j] = m_idx[j] + 1;
                m_pos[j] = m_pos[j] + ks[j];
                for (int k = 0; k < j; k++) begin
                    m_idx[k] = 0; m_pos[k] = m_pos[j];
                end
            end
        end
    endtask

    task automatic cycle(input bit st, input bit sp, input string req);
        @(negedge clk);
        start = st; step = sp;
        @(posedge clk);
        model_edge(st, sp);
        #1;
        check_all(req);
        start = 0; step = 0;
    endtask

    task automatic cfg_write(input int d, input int s, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_dim = 2'(d); cfg_sel = 2'(s); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
        if (s == 0) kb[d] = v;
        else if (s == 1) ks[d] = v;
        else if (s == 2) ki[d] = v[CW-1:0];
    endtask

    task automatic run_to_end(input string req);
        int guard = 0;
        while (m_busy && guard < 2000) begin
            cycle(0, ($urandom % 4) != 0, req);
            guard++;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < NDIM; k++) begin
            kb[k] = 0; ks[k] = 0; ki[k] = 1; m_pos[k] = 0; m_idx[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #0.5;
        check_all("R1");

        // R1: default counts of 1 give a one-element walk at address 0
        cycle(1, 0, "R1");
        chk("R1", AW'(last), 1, "reset-count single element last");
        cycle(0, 1, "R7");
        cycle(0, 1, "R8");
        cycle(0, 0, "R8");

        // directed example: 4x3 matrix in a space 8 wide, base 1
        cfg_write(0, 0, 1); cfg_write(0, 1, 3); cfg_write(0, 2, 3);
        cfg_write(1, 0, 1); cfg_write(1, 1, 8); cfg_write(1, 2, 4);
        cycle(1, 0, "R2");
        chk("R2", addr, 1, "start address");
        cycle(0, 1, "R3");
        chk("R3", addr, 4, "first stride");
        cycle(0, 1, "R3");
        cycle(0, 1, "R4");
        chk("R4", addr, 9, "carry into dim1");
        cycle(0, 0, "R3");
        run_to_end("R4");
        chk("R7", AW'(done), 1, "walk complete");
        chk("R7", addr, 31, "final address held");
        cycle(0, 1, "R8");

        // R11: selector 3 changes nothing
        cfg_write(0, 3, 16'h5555);
        cycle(1, 0, "R11");
        chk("R11", addr, 1, "base unchanged after sel 3");
        // R10: restart mid-walk, start beats step
        cycle(0, 1, "R10");
        cycle(1, 1, "R10");
        chk("R10", addr, 1, "restart address");
        run_to_end("R10");

        // R9: zero count
        cfg_write(2, 2, 0);
        cycle(1, 0, "R9");
        chk("R9", AW'(done), 1, "empty walk done");
        cycle(0, 1, "R9");

        // random walks across all dimensions
        for (int w = 0; w < 60; w++) begin
            for (int k = 0; k < NDIM; k++) begin
                cfg_write(k, 0, AW'($urandom));
                cfg_write(k, 1, AW'($urandom));
                cfg_write(k, 2, (($urandom % 16) == 0) ? 0 : AW'(1 + $urandom % 4));
            end
            cycle(1, 0, "R2");
            for (int g = 0; g < 200 && m_busy; g++) begin
                if (($urandom % 50) == 0) cycle(1, $urandom % 2, "R10");
                else cycle(0, ($urandom % 3) != 0, "R4");
            end
            cycle(0, 1, "R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule